// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Refresh Timer

This block sits at the front of an SDRAM controller and takes the memory from power-on to normal operation. Once reset is released it holds the command bus at NOP for a fixed quiet time derived from the clock frequency. It then issues one precharge to all banks and a run of auto-refresh commands, and finally loads the mode register with the configured CAS latency. After the mode-register load settles, it raises a ready flag.

From that point on, a programmable down-counter measures the refresh interval. Each time the counter expires, one refresh becomes owed. Owed refreshes are issued no closer together than the row-cycle time, and none is dropped when expiries arrive faster than refreshes can go out. A zero interval is a fault: the sequencer parks and never becomes ready. A small combinational output reports the log2 of the memory size in bytes, computed from the geometry codes and the bus-width selection.

The timing inputs are static. The one exception is the refresh interval, which is sampled each time the counter reloads.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset release, the command bus shows NOP for exactly CLK_HZ/1e6 x PAUSE_US cycles. The first command (precharge-all) appears in cycle PAUSE_CYC, counting the first clock edge after release as cycle 1, and it carries address bit 10 high.
- R2: Command encoding on {cs_n, ras_n, cas_n, we_n} is fixed: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode load = 0000. The bank bus is always 0, and refresh and NOP carry address 0.
- R3: The first auto-refresh follows the precharge by cfg_trp cycles. Exactly eight auto-refreshes are issued, each cfg_trc cycles after the previous one, before any mode load.
- R4: The mode load follows the eighth refresh by cfg_trc cycles. Its address holds cfg_cas_lat in bits [6:4] and zeros in bits [3:0], which selects burst length one and sequential burst order.
- R5: init_done rises exactly 3 cycles after the mode-load cycle, with only NOPs in between, and it stays high until reset.
- R6: In normal mode, the first refresh appears cfg_refi+1 cycles after init_done rises. When cfg_refi >= cfg_trc, later refreshes follow every cfg_refi cycles. refresh_pulse is high exactly in the cycles that carry a normal-mode refresh.
- R7: Normal-mode refreshes are at least cfg_trc cycles apart. Every interval expiry is counted, so each expiry yields exactly one refresh, even when an expiry and an issue fall in the same cycle.
- R8: cfg_refi is sampled on entry to normal mode and at each expiry. A changed value takes effect from the next reload.
- R9: If cfg_refi is zero at reset release, cfg_err is high from cycle 1, init_done never rises, and the bus stays at NOP.
- R10: size_log2 = (cfg_col_code+8) + (cfg_row_code+11) + (cfg_bank_code+1) + (cfg_bus16 ? 1 : 2).
- R11: While reset is asserted, the bus shows NOP, and init_done, refresh_pulse and cfg_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 3 | CAS latency written into the mode register |
| cfg_trp | input | 4 | Precharge-to-refresh spacing in cycles |
| cfg_trc | input | 4 | Minimum refresh-to-refresh spacing in cycles |
| cfg_refi | input | 16 | Refresh interval in cycles; zero is a fault |
| cfg_col_code | input | 2 | Column bits minus 8 |
| cfg_row_code | input | 2 | Row bits minus 11 |
| cfg_bank_code | input | 1 | Bank bits minus 1 |
| cfg_bus16 | input | 1 | 1 selects a 16-bit data bus, 0 a 32-bit bus |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address bus |
| init_done | output | 1 | Sequence complete, normal mode entered |
| refresh_pulse | output | 1 | High in each normal-mode refresh cycle |
| cfg_err | output | 1 | Zero refresh interval detected |
| size_log2 | output | 6 | log2 of the memory size in bytes |

## Verification
In normal mode, an interval expiry and the issue of an owed refresh can land in the same clock edge. The pending count must then stay unchanged rather than lose either event. This case is provoked by setting the interval shorter than the row-cycle spacing, so that owed refreshes pile up and, after a few intervals, a tick coincides with an issue. The interval is then stretched so that the backlog drains. The result is judged by the exact cycle of every refresh issued at cfg_trc spacing, and by the total number of refresh pulses, which must equal the number of expiries the bench predicts.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_TRP,
        ST_INITREF,
        ST_TMRD,
        ST_RUN,
        ST_FAULT
    } st_e;

endpackage

// File: rtl/sdram_refi_timer.sv
`timescale 1ns/1ps
// Refresh interval down-counter with a pending-refresh accumulator.
module sdram_refi_timer #(
    parameter int REFI_W = 16,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              issue,
    input  logic [REFI_W-1:0] interval,
    output logic              pend_nz
);
    localparam logic [REFI_W-1:0] C_ONE = 1;
    localparam logic [PEND_W-1:0] P_ONE = 1;

    typedef struct packed {
        logic [REFI_W-1:0] cnt;
        logic [PEND_W-1:0] pend;
    } tmr_t;

    tmr_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (start) begin
            d.cnt = interval;
        end else if (q.cnt != '0) begin
            if (q.cnt == C_ONE) begin
                tick  = 1'b1;
                d.cnt = interval;
            end else begin
                d.cnt = q.cnt - C_ONE;
            end
        end
        // a tick and an issue in one cycle cancel: the count stays put
        if (tick && !issue) begin
            if (q.pend != '1) d.pend = q.pend + P_ONE;
        end else if (!tick && issue) begin
            d.pend = q.pend - P_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_nz = (q.pend != '0);

endmodule

// File: rtl/sdram_cmd_drive.sv
`timescale 1ns/1ps
// Maps an abstract command onto SDRAM strobes and address lines.
module sdram_cmd_drive
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2,
    parameter int CL_W   = 3
) (
    input  cmd_e              cmd,
    input  logic [CL_W-1:0]   cas_lat,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int AP_BIT = 10;
    localparam int CL_LSB = 4;

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_PRE: begin
                ras_n        = 1'b0;
                we_n         = 1'b0;
                addr[AP_BIT] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n                  = 1'b0;
                cas_n                  = 1'b0;
                we_n                   = 1'b0;
                addr[CL_LSB +: CL_W]   = cas_lat;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
// Power-up command sequencer with periodic refresh.
module sdram_init_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PAUSE_US  = 200,
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int TIM_W     = 4,
    parameter int REFI_W    = 16,
    parameter int PEND_W    = 4,
    parameter int INIT_REFS = 8,
    parameter int TMRD_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic [TIM_W-1:0]  cfg_trc,
    input  logic [REFI_W-1:0] cfg_refi,
    input  logic [1:0]        cfg_col_code,
    input  logic [1:0]        cfg_row_code,
    input  logic              cfg_bank_code,
    input  logic              cfg_bus16,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              refresh_pulse,
    output logic              cfg_err,
    output logic [5:0]        size_log2
);
    localparam int PAUSE_CYC = (CLK_HZ / 1_000_000) * PAUSE_US;
    localparam int PW        = $clog2(PAUSE_CYC + 1);
    localparam int WAIT_W    = (PW > TIM_W) ? PW : TIM_W;
    localparam int RCNT_W    = $clog2(INIT_REFS + 1);

    localparam logic [WAIT_W-1:0] W_ONE     = 1;
    localparam logic [WAIT_W-1:0] PAUSE_LD  = WAIT_W'(PAUSE_CYC - 1);
    localparam logic [WAIT_W-1:0] TMRD_LD   = WAIT_W'(TMRD_CYC - 1);
    localparam logic [RCNT_W-1:0] R_ONE     = 1;
    localparam logic [RCNT_W-1:0] REFS_LAST = RCNT_W'(INIT_REFS);

    typedef struct packed {
        st_e               st;
        logic [WAIT_W-1:0] wait_cnt;
        logic [RCNT_W-1:0] refs;
        cmd_e              cmd;
        logic              done;
        logic              err;
        logic              rpulse;
    } seq_t;

    seq_t q, d;

    logic [WAIT_W-1:0] trp_ld, trc_ld;
    logic              tmr_start, tmr_issue, pend_nz;

    // spacing counts of zero behave as one
    always_comb begin
        trp_ld = (cfg_trp == '0) ? '0 : (WAIT_W'(cfg_trp) - W_ONE);
        trc_ld = (cfg_trc == '0) ? '0 : (WAIT_W'(cfg_trc) - W_ONE);
    end

    always_comb begin
        d         = q;
        d.cmd     = CMD_NOP;
        d.rpulse  = 1'b0;
        tmr_start = 1'b0;
        tmr_issue = 1'b0;
        unique case (q.st)
            ST_PAUSE: begin
                if (cfg_refi == '0) begin
                    d.st  = ST_FAULT;
                    d.err = 1'b1;
                end else if (q.wait_cnt == '0) begin
                    d.cmd      = CMD_PRE;
                    d.st       = ST_TRP;
                    d.wait_cnt = trp_ld;
                end else begin
                    d.wait_cnt = q.wait_cnt - W_ONE;
                end
            end
            ST_TRP: begin
                if (q.wait_cnt == '0) begin
                    d.cmd      = CMD_REF;
                    d.refs     = R_ONE;
                    d.st       = ST_INITREF;
                    d.wait_cnt = trc_ld;
                end else begin
                    d.wait_cnt = q.wait_cnt - W_ONE;
                end
            end
            ST_INITREF: begin
                if (q.wait_cnt != '0) begin
                    d.wait_cnt = q.wait_cnt - W_ONE;
                end else if (q.refs == REFS_LAST) begin
                    d.cmd      = CMD_MRS;
                    d.st       = ST_TMRD;
                    d.wait_cnt = TMRD_LD;
                end else begin
                    d.cmd      = CMD_REF;
                    d.refs     = q.refs + R_ONE;
                    d.wait_cnt = trc_ld;
                end
            end
            ST_TMRD: begin
                if (q.wait_cnt == '0) begin
                    d.st      = ST_RUN;
                    d.done    = 1'b1;
                    tmr_start = 1'b1;
                end else begin
                    d.wait_cnt = q.wait_cnt - W_ONE;
                end
            end
            ST_RUN: begin
                if (q.wait_cnt != '0) begin
                    d.wait_cnt = q.wait_cnt - W_ONE;
                end else if (pend_nz) begin
                    d.cmd      = CMD_REF;
                    d.rpulse   = 1'b1;
                    d.wait_cnt = trc_ld;
                    tmr_issue  = 1'b1;
                end
            end
            default: begin
                d.st  = ST_FAULT;
                d.err = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_PAUSE;
            q.wait_cnt <= PAUSE_LD;
            q.cmd      <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    sdram_refi_timer #(
        .REFI_W (REFI_W),
        .PEND_W (PEND_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .issue    (tmr_issue),
        .interval (cfg_refi),
        .pend_nz  (pend_nz)
    );

    sdram_cmd_drive #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .CL_W   (3)
    ) u_drive (
        .cmd     (q.cmd),
        .cas_lat (cfg_cas_lat),
        .cs_n    (sd_cs_n),
        .ras_n   (sd_ras_n),
        .cas_n   (sd_cas_n),
        .we_n    (sd_we_n),
        .ba      (sd_ba),
        .addr    (sd_addr)
    );

    assign init_done     = q.done;
    assign refresh_pulse = q.rpulse;
    assign cfg_err       = q.err;
    assign size_log2     = 6'(cfg_col_code) + 6'd8 + 6'(cfg_row_code) + 6'd11
                         + 6'(cfg_bank_code) + 6'd1 + (cfg_bus16 ? 6'd1 : 6'd2);

endmodule

// File: rtl/sdram_init_seq_chk.sv
`timescale 1ns/1ps
module sdram_init_seq_chk #(
    parameter int PAUSE_CYC = 10000,
    parameter int INIT_REFS = 8,
    parameter int ADDR_W    = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done,
    input logic              refresh_pulse,
    input logic              cfg_err,
    input logic              pend_nz
);
    logic is_nop, is_pre, is_ref, is_mrs;
    int   since_rst;
    int   boot_refs;

    assign is_nop = !cs_n &&  ras_n &&  cas_n &&  we_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 0;
            boot_refs <= 0;
        end else begin
            if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
            if (is_ref && !init_done)  boot_refs <= boot_refs + 1;
        end
    end

    // R1
    quiet_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PAUSE_CYC) |-> is_nop);
    // R1
    prech_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[10]);
    // R2
    cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n);
    // R3
    boot_ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (boot_refs == INIT_REFS));
    // R5
    mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> (is_nop && !init_done));
    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R9
    fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!init_done && is_nop));
    // R6
    pulse_is_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |-> (is_ref && init_done));
    // R7
    pulse_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |-> $past(pend_nz));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .PAUSE_CYC (PAUSE_CYC),
    .INIT_REFS (INIT_REFS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (sd_cs_n),
    .ras_n         (sd_ras_n),
    .cas_n         (sd_cas_n),
    .we_n          (sd_we_n),
    .addr          (sd_addr),
    .init_done     (init_done),
    .refresh_pulse (refresh_pulse),
    .cfg_err       (cfg_err),
    .pend_nz       (pend_nz)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

    localparam int P = 10000;   // 200 us at 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'd3;
    logic [3:0]  cfg_trp = 4'd3;
    logic [3:0]  cfg_trc = 4'd7;
    logic [15:0] cfg_refi = 16'd40;
    logic [1:0]  cfg_col_code = 2'd1;
    logic [1:0]  cfg_row_code = 2'd2;
    logic        cfg_bank_code = 1'b1;
    logic        cfg_bus16 = 1'b0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic        init_done, refresh_pulse, cfg_err;
    logic [5:0]  size_log2;

    sdram_init_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_trp(cfg_trp),
        .cfg_trc(cfg_trc), .cfg_refi(cfg_refi), .cfg_col_code(cfg_col_code),
        .cfg_row_code(cfg_row_code), .cfg_bank_code(cfg_bank_code),
        .cfg_bus16(cfg_bus16), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .init_done(init_done), .refresh_pulse(refresh_pulse), .cfg_err(cfg_err),
        .size_log2(size_log2)
    );

    always #10 clk = ~clk;

    typedef struct {
        int at;
        int kind;   // 1 precharge, 2 refresh, 3 mode load
        int addr;
    } exp_t;

    exp_t expq[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   cyc = 0;
    int   pulses = 0;
    bit   mon_en = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic push(input int at, input int kind, input int addr);
        exp_t e;
        e.at = at; e.kind = kind; e.addr = addr;
        expq.push_back(e);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // boot script: returns the cycle in which init_done must rise
    task automatic push_boot(input int trp, input int trc, input int cl, output int n);
        push(P, 1, 32'h400);                        // R1
        for (int i = 0; i < 8; i++) push(P + trp + i * trc, 2, 0);  // R3
        push(P + trp + 8 * trc, 3, cl << 4);        // R4
        n = P + trp + 8 * trc + 3;                  // R5
    endtask

    task automatic do_reset;
        mon_en = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R11 nop in reset",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        check({init_done, refresh_pulse, cfg_err} == 3'b000, "R11 flags in reset",
              int'({init_done, refresh_pulse, cfg_err}), 0);
        expq.delete();
        pulses = 0;
        rst_n  = 1'b1;
        mon_en = 1'b1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // monitor: pops the scoreboard as commands appear
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            int kind;
            case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
                4'b0111: kind = 0;
                4'b0010: kind = 1;
                4'b0001: kind = 2;
                4'b0000: kind = 3;
                default: kind = -1;
            endcase
            if (refresh_pulse) pulses++;
            if (kind < 0)
                check(1'b0, "R2 illegal strobes",
                      int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
            else if (kind > 0) begin
                if (expq.size() == 0)
                    check(1'b0, "R2 unexpected command", kind, 0);
                else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(cyc == e.at, "R3/R6 command cycle", cyc, e.at);
                    check(kind == e.kind, "R2 command kind", kind, e.kind);
                    check(int'(sd_addr) == e.addr, "R4 command address", int'(sd_addr), e.addr);
                    check(sd_ba == 2'b00, "R2 bank bus", int'(sd_ba), 0);
                end
            end
            if (refresh_pulse || (kind == 2 && init_done))
                check(refresh_pulse == (kind == 2 && init_done), "R6 refresh_pulse",
                      int'(refresh_pulse), int'(kind == 2 && init_done));
        end
    end

    initial begin
        int n;
        // ---- scenario A: nominal boot, interval longer than tRC
        cfg_cas_lat = 3'd3; cfg_trp = 4'd3; cfg_trc = 4'd7; cfg_refi = 16'd40;
        do_reset();
        push_boot(3, 7, 3, n);
        for (int j = 0; j < 4; j++) push(n + 41 + 40 * j, 2, 0);   // R6
        #1;
        check(size_log2 == 6'd26, "R10 size 32-bit bus", int'(size_log2), 26);
        cfg_bus16 = 1'b1;
        #1;
        check(size_log2 == 6'd25, "R10 size 16-bit bus", int'(size_log2), 25);
        cfg_bus16 = 1'b0;
        wait_cyc(n - 1);
        check(init_done == 1'b0, "R5 done not early", int'(init_done), 0);
        wait_cyc(n);
        check(init_done == 1'b1, "R5 done after tMRD", int'(init_done), 1);
        wait_cyc(n + 41 + 120 + 20);
        check(expq.size() == 0, "R6 missing commands", expq.size(), 0);
        check(pulses == 4, "R6 pulse count", pulses, 4);

        // ---- scenario B: zero interval is a fault
        cfg_refi = 16'd0;
        do_reset();
        wait_cyc(1);
        check(cfg_err == 1'b1, "R9 error flag", int'(cfg_err), 1);
        wait_cyc(P + 500);
        check(init_done == 1'b0, "R9 never ready", int'(init_done), 0);
        check(cfg_err == 1'b1, "R9 error held", int'(cfg_err), 1);

        // ---- scenario C: interval shorter than tRC, backlog then drain
        cfg_cas_lat = 3'd2; cfg_trp = 4'd1; cfg_trc = 4'd9; cfg_refi = 16'd4;
        do_reset();
        push_boot(1, 9, 2, n);
        // expiries at n+4 .. n+44 (11), issued at tRC spacing: R7
        for (int j = 0; j < 11; j++) push(n + 5 + 9 * j, 2, 0);
        wait_cyc(n + 40);
        cfg_refi = 16'd1000;        // R8: takes effect at the reload in n+44
        wait_cyc(n + 600);
        check(expq.size() == 0, "R7 missing refreshes", expq.size(), 0);
        check(pulses == 11, "R7 expiries equal refreshes", pulses, 11);

        mon_en = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule